// File: doc/BRIEF.md
# Entropy-Mixing CRC Random Core

This block is the digital half of a hardware random number source. Three raw entropy bits arrive every clock. Each has its own enable. The enabled bits are combined by XOR, and the result feeds a 64-bit CRC shift register that advances on every clock. The CRC state is the random word. Software can only read it, through a valid/ready read port.

A control register holds four fields: the source enables, an interlock mode bit, a two-bit output selector and a minimum-wait count. When the interlock is on, the read port raises `rd_valid` only after at least the wait count of clock cycles have passed since the last accepted read, which lets fresh entropy build up. When the interlock is off, the current CRC word can be read on any cycle. The selector has a quiet setting that forces the data lines to zero for diagnostics while the CRC keeps running.

Read-port back-pressure rules:
- A read is accepted in a cycle where both `rd_valid` and `rd_ready` are high.
- The consumer may hold `rd_ready` low for as long as it likes.
- `rd_valid` never drops on its own once raised; only an accepted read, reset or a control write can lower it.
- Holding `rd_ready` high while `rd_valid` is low has no effect.

Top module: `rng_core`

## Requirements
- R1: A synchronous reset clears the CRC, the cycle counter and the whole control register. After reset `rd_data` reads 0 and `rd_valid` is 1, because the interlock is off.
- R2: Source i (`ent_i[i]`) takes part only while control bit i is set. With all three enables clear, the CRC does not move from zero whatever the inputs do.
- R3: Each clock the feedback bit is the CRC's bit 63 XOR the mixed entropy bit. The CRC shifts left by one with a 0 entering at bit 0, and the result is XORed with 64'h231D_CEE9_1262_B8A3 when the feedback bit is 1. These are the low 64 bits of the polynomial with terms 64, 61, 57, 56, 52, 51, 50, 48, 47, 46, 43, 42, 41, 39, 38, 37, 35, 32, 28, 25, 22, 21, 17, 15, 13, 12, 11, 7, 5, 1 and 0.
- R4: An accepted read returns the CRC word present in that cycle and does not disturb how the CRC advances.
- R5: With the interlock bit (control bit 3) set, `rd_valid` is high only when the counter is at least the wait field (control bits 21:6).
- R6: The counter goes to 0 on the clock edge that accepts a read. Otherwise it increments once per clock and stops at its maximum. With the interlock on and a wait above 0, `rd_valid` is low in the cycle after an accepted read.
- R7: With the interlock bit clear, `rd_valid` is high in every cycle.
- R8: Output selector value 3 (control bits 5:4) drives `rd_data` to zero while the CRC keeps advancing. Any other value drives the CRC word.
- R9: A cycle with `ctl_wr` high loads all of `ctl_wdata` into the control register on that edge, and the new fields act from the next cycle.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and the counter is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ent_i | input | 3 | Raw entropy bits, one per source |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 22 | Control value: enables[2:0], interlock[3], selector[5:4], wait[21:6] |
| rd_valid | output | 1 | Random word may be taken |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 64 | Random word (zero when quiet) |

## Verification
Every result here appears one clock edge after its cause. The CRC step, the counter restart on an accepted read and a control write all take effect on the edge that samples them. `rd_valid` and `rd_data` are combinational views of those registers, so they can be observed in the cycle that follows. The bench drives inputs and compares outputs on the falling edge. Its reference model steps on the rising edge, using the same sampled inputs, so each comparison lines up exactly with the state produced one edge earlier. The control-write case is checked directly: the new interlock must lower `rd_valid` in the cycle right after the write.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int NSRC   = 3;
  localparam int DATA_W = 64;
  localparam int WAIT_W = 16;
  localparam int SEL_W  = 2;
  localparam int CTL_W  = NSRC + 1 + SEL_W + WAIT_W;
  localparam logic [DATA_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;
  localparam logic [SEL_W-1:0]  SEL_QUIET = 2'b11;

  typedef struct packed {
    logic [WAIT_W-1:0] wait_cyc;
    logic [SEL_W-1:0]  out_sel;
    logic              interlock;
    logic [NSRC-1:0]   src_en;
  } rng_ctl_t;
endpackage

// File: rtl/rng_mix.sv
module rng_mix #(
  parameter int N = 3
) (
  input  logic [N-1:0] ent_i,
  input  logic [N-1:0] en_i,
  output logic         mix_o
);
  logic [N-1:0] gated;
  for (genvar g = 0; g < N; g++) begin : g_src
    assign gated[g] = ent_i[g] & en_i[g];
  end
  assign mix_o = ^gated;
endmodule

// File: rtl/rng_crc.sv
module rng_crc #(
  parameter int          W    = 64,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mix_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = state_q[W-1] ^ mix_i;

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= {state_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign state_o = state_q;

  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_q == '0 && !mix_i) |=> state_q == '0); // R2
  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!state_q[W-1] && !mix_i) |=> state_q == {$past(state_q[W-2:0]), 1'b0}); // R3
endmodule

// File: rtl/rng_gate.sv
module rng_gate #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          interlock,
  input  logic [CW-1:0] wait_cyc,
  input  logic          rd_ready,
  output logic          rd_valid
);
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign rd_valid = !interlock || (cnt_q >= wait_cyc);
  assign accept   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (accept)         cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    (interlock && rd_valid && !rd_ready) |=>
      (rd_valid || !$stable(wait_cyc) || !$stable(interlock))); // R10
  AST_ACCEPT_STALL: assert property (@(posedge clk) disable iff (rst)
    (interlock && accept) |=>
      (!rd_valid || wait_cyc == '0 || !interlock || !$stable(wait_cyc))); // R6
endmodule

// File: rtl/rng_core.sv
module rng_core
  import rng_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     ent_i,
  input  logic                ctl_wr,
  input  logic [CTL_W-1:0]    ctl_wdata,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [DATA_W-1:0]   rd_data
);
  rng_ctl_t          ctl_q;
  logic              mix;
  logic [DATA_W-1:0] crc;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_wr) ctl_q <= rng_ctl_t'(ctl_wdata);
  end

  rng_mix #(.N(NSRC)) u_mix (
    .ent_i (ent_i),
    .en_i  (ctl_q.src_en),
    .mix_o (mix)
  );

  rng_crc #(.W(DATA_W), .POLY(CRC_POLY)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .mix_i   (mix),
    .state_o (crc)
  );

  rng_gate #(.CW(WAIT_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .interlock (ctl_q.interlock),
    .wait_cyc  (ctl_q.wait_cyc),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid)
  );

  assign rd_data = (ctl_q.out_sel == SEL_QUIET) ? '0 : crc;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (crc == '0 && ctl_q == '0 && rd_valid)); // R1
  AST_FREE_READ: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_wdata[NSRC]) |=> rd_valid); // R7
endmodule

// File: tb/rng_core_test.sv
`timescale 1ns/1ps
module rng_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ent_i = '0;
  logic        ctl_wr = 1'b0;
  logic [21:0] ctl_wdata = '0;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rng_core uut (
    .clk(clk), .rst(rst), .ent_i(ent_i), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data)
  );

  // reference model
  logic [63:0] poly_m;
  logic [63:0] crc_m = '0;
  int          cnt_m = 0;
  logic [2:0]  en_m = '0;
  logic        mode_m = 0;
  logic [1:0]  sel_m = '0;
  int          wait_m = 0;
  bit          acc_prev = 0;

  initial begin
    int terms[30] = '{61,57,56,52,51,50,48,47,46,43,42,41,39,38,37,35,
                      32,28,25,22,21,17,15,13,12,11,7,5,1,0};
    poly_m = '0;
    foreach (terms[i]) poly_m[terms[i]] = 1'b1;
  end

  function automatic bit valid_m();
    return !mode_m || (cnt_m >= wait_m);
  endfunction

  function automatic logic [63:0] data_m();
    return (sel_m == 2'b11) ? 64'h0 : crc_m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      crc_m = '0; cnt_m = 0; en_m = '0; mode_m = 0; sel_m = '0; wait_m = 0;
      acc_prev = 0;
    end else begin
      bit acc;
      bit fb;
      acc = valid_m() && rd_ready;
      fb = crc_m[63] ^ (^(ent_i & en_m));
      crc_m = (crc_m << 1) ^ (fb ? poly_m : 64'h0);
      if (acc) cnt_m = 0;
      else if (cnt_m < 65535) cnt_m = cnt_m + 1;
      if (ctl_wr) begin
        en_m = ctl_wdata[2:0]; mode_m = ctl_wdata[3];
        sel_m = ctl_wdata[5:4]; wait_m = int'(ctl_wdata[21:6]);
      end
      acc_prev = acc;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle compare on falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      string vt, dt;
      vt = !mode_m ? "R7" : (cnt_m == 0 ? "R6" : (cnt_m < wait_m ? "R5" : "R10"));
      dt = (sel_m == 2'b11) ? "R8" : (acc_prev ? "R4" : (en_m == 0 ? "R2" : "R3"));
      chk(rd_valid == valid_m(), vt, 64'(rd_valid), 64'(valid_m()));
      chk(rd_data == data_m(), dt, rd_data, data_m());
    end
  end

  task automatic wr_ctl(input logic [2:0] en, input bit mode,
                        input logic [1:0] sel, input logic [15:0] w);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = {w, sel, mode, en};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic run(input int n, input int ready_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ent_i = 3'($urandom);
      case (ready_mode)
        0: rd_ready = 1'b0;
        1: rd_ready = 1'b1;
        default: rd_ready = 1'($urandom);
      endcase
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 64'h0, "R1 data after reset", rd_data, 64'h0);
    chk(rd_valid == 1'b1, "R1 valid after reset", 64'(rd_valid), 64'h1);

    run(10, 2);                      // all sources off
    chk(rd_data == 64'h0, "R2 disabled sources", rd_data, 64'h0);

    wr_ctl(3'b111, 0, 2'b00, 16'd0);
    run(30, 2);
    wr_ctl(3'b101, 0, 2'b01, 16'd0);
    run(20, 2);
    wr_ctl(3'b010, 1, 2'b00, 16'd4);
    run(60, 2);
    wr_ctl(3'b111, 1, 2'b11, 16'd3);
    run(15, 2);
    wr_ctl(3'b111, 1, 2'b10, 16'd3);
    run(10, 2);
    wr_ctl(3'b110, 1, 2'b00, 16'd0);
    run(10, 2);

    // control write in the same cycle as an accepted free read
    wr_ctl(3'b111, 0, 2'b00, 16'd0);
    @(negedge clk);
    rd_ready = 1'b1;
    ctl_wr = 1'b1;
    ctl_wdata = {16'd7, 2'b00, 1'b1, 3'b111};
    @(negedge clk);
    ctl_wr = 1'b0;
    rd_ready = 1'b0;
    chk(rd_valid == 1'b0, "R9 new wait acts next cycle", 64'(rd_valid), 64'h0);
    run(12, 0);
    chk(rd_valid == 1'b1, "R10 valid held without ready", 64'(rd_valid), 64'h1);

    wr_ctl(3'b111, 1, 2'b00, 16'd20);
    run(100, 1);
    run(40, 2);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(rd_data == 64'h0, "R1 data after second reset", rd_data, 64'h0);
    chk(rd_valid == 1'b1, "R1 valid after second reset", 64'(rd_valid), 64'h1);
    run(5, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule